// File: doc/BRIEF.md
# HDLC transmit framer

This block turns a byte stream into a bit-oriented HDLC/SDLC line signal. Bytes arrive on a ready/valid port, and each byte carries a start-of-frame and an end-of-frame marker. For each frame the block sends an optional preamble byte and an opening flag. It then sends the data bytes least significant bit first, followed by a frame check sequence of 16 or 32 bits and at least one closing flag. Zero-bit insertion is applied to the data and check-sequence bits.

The line advances one bit on every cycle in which `bit_en` is high, and it never leaves a gap. Between frames the line carries a programmable idle pattern: either continuous ones or continuous flags. When the next frame is already waiting as the closing flag ends, the block sends a programmable number of flags between the two frames and starts the next frame without returning to idle. Input is held in a single one-byte register that is consumed at byte boundaries of the line.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `txd` is 1 and `in_ready` is 1. While no frame is being sent, the line carries all ones when `idle_flags`=0, or repeated 0x7E flags (LSB first) when `idle_flags`=1.
- R2: A frame on the line is an opening flag 0x7E, then the data bytes each sent LSB first, then the check sequence sent low byte first and LSB first, then a closing flag 0x7E.
- R3: After any five consecutive ones in the data or check-sequence bits, a single 0 is inserted. This applies even when the fifth one is the last bit before the closing flag. Flags and the preamble are never stuffed.
- R4: With `crc32_sel`=0 the check sequence is the inverted CRC-16 (polynomial x^16+x^12+x^5+1, reflected, preset all ones). For the ASCII bytes "123456789" it is 0x906E, sent as 0x6E then 0x90.
- R5: With `crc32_sel`=1 the check sequence is the inverted reflected CRC-32 (polynomial 0x04C11DB7, preset all ones). For "123456789" it is 0xCBF43926, sent as 0x26, 0x39, 0xF4, 0xCB.
- R6: When the start byte of the next frame is already waiting as the closing flag ends, exactly `flag_gap` flags separate the two frames. The closing flag counts among them, and a `flag_gap` of 0 acts as 1.
- R7: When `pre_en`=1 and a frame starts from the idle line, the byte `pre_pattern` is sent LSB first, unstuffed, directly before the opening flag. Frames that follow back to back get no preamble.
- R8: `txd` changes only on cycles where `bit_en` is high, and one line bit is emitted per such cycle.
- R9: The input holds one byte: `in_ready` is low from the cycle after an accepted byte until that byte is consumed.
- R10: A byte without `in_sof` that arrives while the line is idle, or after a closing flag, is discarded and starts no frame.
- R11: If no byte is waiting when a data byte finishes, and that byte had no `in_eof`, the frame is closed with its check sequence and a closing flag, exactly as if `in_eof` had been set.
- R12: If no new frame is waiting when the closing flag completes, the idle pattern follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Transmit bit enable, one line bit per high cycle |
| crc32_sel | input | 1 | 0: 16-bit check sequence, 1: 32-bit check sequence |
| flag_gap | input | GAP_W | Number of flags between back-to-back frames (0 acts as 1) |
| idle_flags | input | 1 | Idle pattern: 0 all ones, 1 continuous flags |
| pre_en | input | 1 | Send a preamble before frames that start from idle |
| pre_pattern | input | 8 | Preamble byte |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first byte of a frame |
| in_eof | input | 1 | Byte is the last byte of a frame |
| in_ready | output | 1 | Holding register is free |
| txd | output | 1 | Serial line data |

## Verification
Two situations are the hardest to reach from the ports. The first is a back-to-back transition: the next frame's start byte must sit in the holding register at the moment the closing flag ends. The second is a run of five ones that ends exactly at the check-sequence boundary or the flag boundary. The stimulus refills the holding register on the first cycle `in_ready` returns, so the next frame always waits behind the current one. The data bytes include 0xFF and 0x7E to force stuffing at every byte position. A sweep covers every flag gap from 0 to 4 under both check-sequence widths, with different enable rates and idle patterns. The line is rebuilt by a receiver model in the bench that removes stuffed zeros and splits the stream at flags.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             crc32_sel,
  input  logic [GAP_W-1:0] flag_gap,
  input  logic             idle_flags,
  input  logic             pre_en,
  input  logic [7:0]       pre_pattern,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             in_ready,
  output logic             txd
);
  localparam logic [7:0]  FLAG      = 8'h7E;
  localparam logic [4:0]  BYTE_LAST = 5'd7;
  localparam logic [4:0]  F16_LAST  = 5'd15;
  localparam logic [4:0]  F32_LAST  = 5'd31;
  localparam logic [2:0]  RUN_MAX   = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_OPEN, S_DATA, S_FCS, S_CLOSE} st_t;

  st_t              st;
  logic [31:0]      sh, crc, crc_nx;
  logic [4:0]       bitcnt, last_idx;
  logic [2:0]       ones;
  logic [GAP_W-1:0] nflags, gap;
  logic             hv, h_sof, h_eof, cur_eof;
  logic [7:0]       h_data, idle_pat;
  logic             stuff, unit_end, fb, start_ok, take;

  assign stuff    = ones == RUN_MAX;
  assign last_idx = (st == S_FCS) ? (crc32_sel ? F32_LAST : F16_LAST) : BYTE_LAST;
  assign unit_end = bit_en && !stuff && bitcnt == last_idx;
  assign gap      = (flag_gap == '0) ? GAP_W'(1) : flag_gap;
  assign idle_pat = idle_flags ? FLAG : 8'hFF;
  assign start_ok = hv && h_sof;
  assign in_ready = !hv;

  assign fb     = crc[0] ^ sh[0];
  assign crc_nx = crc32_sel ? ((crc >> 1) ^ (fb ? 32'hEDB88320 : 32'h0))
                            : {16'h0, (crc[15:0] >> 1) ^ (fb ? 16'h8408 : 16'h0)};

  assign take = unit_end && hv &&
                ((st == S_IDLE && !h_sof) || st == S_OPEN || (st == S_DATA && !cur_eof) ||
                 (st == S_CLOSE && (!h_sof || nflags >= gap)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv <= 1'b0; h_sof <= 1'b0; h_eof <= 1'b0; h_data <= '0;
    end else if (in_valid && !hv) begin
      hv <= 1'b1; h_sof <= in_sof; h_eof <= in_eof; h_data <= in_data;
    end else if (take) begin
      hv <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= 32'hFF; txd <= 1'b1; bitcnt <= '0; ones <= '0;
      crc <= '1; cur_eof <= 1'b0; nflags <= '0;
    end else if (bit_en && stuff) begin
      txd  <= 1'b0;
      ones <= '0;
    end else if (bit_en) begin
      txd    <= sh[0];
      sh     <= sh >> 1;
      ones   <= ((st == S_DATA || st == S_FCS) && sh[0]) ? ones + 3'd1 : 3'd0;
      bitcnt <= unit_end ? 5'd0 : bitcnt + 5'd1;
      if (st == S_DATA) crc <= crc_nx;
      if (unit_end) begin
        case (st)
          S_IDLE:
            if (start_ok) begin
              st <= pre_en ? S_PRE : S_OPEN;
              sh <= {24'h0, pre_en ? pre_pattern : FLAG};
            end else sh <= {24'h0, idle_pat};
          S_PRE: begin st <= S_OPEN; sh <= {24'h0, FLAG}; end
          S_OPEN: begin
            st <= S_DATA; sh <= {24'h0, h_data}; cur_eof <= h_eof; crc <= '1;
          end
          S_DATA:
            if (hv && !cur_eof) begin
              sh <= {24'h0, h_data}; cur_eof <= h_eof;
            end else begin
              st <= S_FCS; sh <= ~crc_nx;
            end
          S_FCS: begin st <= S_CLOSE; sh <= {24'h0, FLAG}; nflags <= GAP_W'(1); end
          default:
            if (start_ok && nflags < gap) begin
              sh <= {24'h0, FLAG}; nflags <= nflags + GAP_W'(1);
            end else if (start_ok) begin
              st <= S_DATA; sh <= {24'h0, h_data}; cur_eof <= h_eof; crc <= '1;
            end else begin
              st <= S_IDLE; sh <= {24'h0, idle_pat};
            end
        endcase
      end
    end
  end

  a_r8_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));
  a_r3_zero_after_five: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ones == RUN_MAX) |=> !txd);
  a_r3_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX);
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nflags <= gap);
endmodule

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
  localparam int CLK_P = 10;
  localparam int GW    = 4;
  localparam int MAXC  = 4096;

  logic clk = 0, rst_n = 0, bit_en = 0, crc32_sel = 0, idle_flags = 0, pre_en = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0;
  logic [GW-1:0] flag_gap = '0;
  logic [7:0] pre_pattern = 8'hAA, in_data = '0;
  logic in_ready, txd;

  hdlc_tx_framer #(.GAP_W(GW)) i_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crc32_sel(crc32_sel), .flag_gap(flag_gap),
    .idle_flags(idle_flags), .pre_en(pre_en), .pre_pattern(pre_pattern), .in_valid(in_valid),
    .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .txd(txd));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int dv = 1, ph = 0, ncap = 0, hold_err = 0;
  bit cap_on = 0;
  bit cap [0:MAXC-1];
  logic prev_txd = 1;

  logic [7:0] fd [0:3][0:15];
  int fl [0:3];
  bit rb [0:511];
  logic [7:0] seg_b [0:63][0:47];
  int seg_n [0:63], seg_e [0:63], nseg;
  logic [7:0] ex_b [0:15][0:47];
  int ex_n [0:15], ex_e [0:15], ne;
  logic [7:0] tmp [0:47];

  always @(negedge clk) begin
    if (cap_on) begin
      if (bit_en) begin
        if (ncap < MAXC) cap[ncap] = txd;
        ncap++;
      end else if (txd !== prev_txd) hold_err++;
    end
    prev_txd = txd;
    ph = (ph + 1 >= dv) ? 0 : ph + 1;
    bit_en = (ph == dv - 1);
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [31:0] calc_fcs(input int f, input int n, input bit w);
    logic [31:0] c;
    logic b;
    c = w ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        b = fd[f][i][j] ^ c[0];
        c = c >> 1;
        if (b) c = c ^ (w ? 32'hEDB88320 : 32'h00008408);
      end
    return w ? ~c : {16'h0, ~c[15:0]};
  endfunction

  task automatic decode();
    int ones, nb, emp;
    ones = 0; nb = 0; emp = 0; nseg = 0;
    for (int i = 0; i < ncap && i < MAXC; i++) begin
      if (cap[i]) begin
        ones++;
        if (ones >= 7) begin nb = 0; emp = 0; end
        else if (nb < 512) begin rb[nb] = 1; nb++; end
      end else if (ones == 5) begin
        ones = 0;
      end else if (ones == 6) begin
        nb = (nb >= 7) ? nb - 7 : 0;
        if (nb == 0) emp++;
        else if (nseg < 64) begin
          seg_n[nseg] = nb; seg_e[nseg] = emp;
          for (int k = 0; k < 48 && k < nb / 8; k++)
            for (int j = 0; j < 8; j++) seg_b[nseg][k][j] = rb[8*k+j];
          nseg++; emp = 0;
        end
        nb = 0; ones = 0;
      end else begin
        if (ones >= 7) nb = 0;
        if (nb < 512) begin rb[nb] = 0; nb++; end
        ones = 0;
      end
    end
  endtask

  task automatic push_exp(input int nbytes, input int e);
    ex_n[ne] = 8 * nbytes; ex_e[ne] = e;
    for (int k = 0; k < nbytes; k++) ex_b[ne][k] = tmp[k];
    ne++;
  endtask

  task automatic run(input string tag, input bit w, input int g, input bit idl, input bit pre,
                     input int d, input bit drop, input bit ur, input bit kv, input int nf);
    int len, fw, ones_tail;
    logic [31:0] fcs;
    bit ok;
    if (kv) begin
      for (int i = 0; i < 9; i++) fd[0][i] = 8'h31 + 8'(i);
      fl[0] = 9;
    end else
      for (int f = 0; f < 4; f++) begin
        fl[f] = 2 + ((f + g + int'(w)) % 4);
        for (int i = 0; i < 16; i++)
          fd[f][i] = (i % 4 == 1) ? 8'hFF : (i % 4 == 2) ? 8'h7E : 8'((f*53 + i*29 + g*7 + int'(w)) & 255);
      end
    rst_n = 0; cap_on = 0;
    crc32_sel = w; flag_gap = GW'(g); idle_flags = idl; pre_en = pre; dv = d;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 reset line level", txd, 1);
    chk(in_ready === 1'b1, "R9 reset ready", in_ready, 1);
    rst_n = 1; ncap = 0; hold_err = 0; cap_on = 1;
    if (drop) send_byte(8'h3C, 0, 1);
    for (int f = 0; f < nf; f++) begin
      len = ur ? 1 : fl[f];
      for (int i = 0; i < len; i++) begin
        send_byte(fd[f][i], i == 0, !ur && i == len - 1);
        if (f == 0 && i == 0) chk(in_ready === 1'b0, "R9 ready low while byte held", in_ready, 0);
      end
    end
    repeat (130 * d) @(negedge clk);
    cap_on = 0;
    ne = 0;
    if (pre) begin tmp[0] = 8'hAA; push_exp(1, -1); end
    fw = w ? 4 : 2;
    for (int f = 0; f < nf; f++) begin
      len = ur ? 1 : fl[f];
      for (int i = 0; i < len; i++) tmp[i] = fd[f][i];
      fcs = kv ? (w ? 32'hCBF43926 : 32'h0000906E) : calc_fcs(f, len, w);
      for (int k = 0; k < fw; k++) tmp[len+k] = fcs[8*k +: 8];
      push_exp(len + fw, f == 0 ? (pre ? 0 : -1) : ((g == 0 ? 1 : g) - 1));
    end
    decode();
    chk(nseg == ne, {tag, " segment count"}, nseg, ne);
    for (int k = 0; k < nseg && k < ne; k++) begin
      ok = seg_n[k] == ex_n[k];
      for (int j = 0; ok && j < ex_n[k] / 8; j++) ok = seg_b[k][j] == ex_b[k][j];
      chk(ok, (pre && k == 0) ? "R7 preamble before opening flag" : {tag, " frame contents"},
          ok ? 0 : seg_n[k], ok ? 0 : ex_n[k]);
      if (ex_e[k] >= 0)
        chk(seg_e[k] == ex_e[k], "R6 flags between frames", seg_e[k] + 1, ex_e[k] + 1);
    end
    ones_tail = 0;
    for (int i = ncap - 16; i < ncap; i++) if (i >= 0 && i < MAXC) ones_tail += int'(cap[i]);
    chk(ones_tail == (idl ? 12 : 16), "R1 R12 idle pattern after frames", ones_tail, idl ? 12 : 16);
    chk(hold_err == 0, "R8 line holds without enable", hold_err, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    run("R4", 0, 1, 0, 0, 1, 0, 0, 1, 1);
    run("R5", 1, 1, 1, 0, 2, 0, 0, 1, 1);
    run("R11", 0, 2, 1, 0, 1, 0, 1, 0, 1);
    run("R10", 1, 0, 0, 1, 2, 1, 0, 0, 2);
    for (int g = 0; g <= 4; g++)
      for (int w = 0; w <= 1; w++)
        run("R2 R3", w[0], g, ((g + w) % 2) == 1, (g % 2) == 1, 1 + (g + w) % 3, 0, 0, 0, 3);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule